// File: doc/BRIEF.md
# CAN Transmit Arbitration and Error Monitor

This block sits between a CAN frame serializer and the bus transceiver. At each sample point it compares the bit this node is sending with the level read back from the wired-AND bus. A dominant level (0) overrides a recessive level (1), so several nodes can transmit at once. The direction of a mismatch decides the outcome. If the node sent recessive but reads dominant inside the arbitration field, another node has priority: this node stops driving and listens. Any other mismatch is a bit error. A recessive acknowledge slot is an acknowledgement error. Both kinds of error request an error frame. After the error or the lost arbitration, the block waits until the bus has been idle and then asks the serializer to send the same frame again.

A transmit error counter rises with each error and falls with each frame that completes cleanly. It drives an error-passive flag and a bus-off state. In bus-off the node stops driving entirely until an external recovery pulse arrives. The bit stream is qualified by `bit_stb`, a one-cycle strobe that acts as a valid with no ready: the block accepts every strobe and never applies back-pressure. All other pins are plain control and status levels or pulses. Bit timing, stuffing, CRC and serialization are done elsewhere.

Top module: `can_tx_guard`

## Requirements
- R1: In the arbitration field (`in_arb_field`=1), sending 1 and reading 0 is a lost arbitration. After that strobe `tx_en` goes to 0 and `arb_lost` goes to 1. `err_req` stays 0 and the error counter is not changed.
- R2: When every strobed bit reads back equal to the bit sent, no loss and no error is flagged. This holds even when other nodes send identical bits.
- R3: Sending 0 and reading 1 is a bit error in any field, the arbitration field included. It raises a one-cycle `err_req` pulse and adds 8 to the error counter. `arb_lost` stays 0.
- R4: Outside the arbitration field and the acknowledge slot, sending 1 and reading 0 is a bit error (as in R3) and not a lost arbitration.
- R5: In the acknowledge slot (`in_ack_slot`=1), sending 1 and reading 1 is an acknowledgement error, handled as in R3. Reading 0 there is a valid acknowledge.
- R6: After an error or a lost arbitration, further strobes are not judged. `retx_req` pulses for one cycle after the 11th consecutive strobe that reads 1, and a read of 0 restarts the count. At that pulse `arb_lost` clears and `tx_en` returns to 1.
- R7: A strobe with `last_bit`=1 and no mismatch completes a frame and lowers the counter by 1, never below 0.
- R8: `err_passive` is 1 exactly while the counter is 128 or more.
- R9: When the counter exceeds 255, `bus_off` goes to 1 together with the error's `err_req` pulse. `tx_en` then stays 0, and strobes raise no `err_req` and no `retx_req`. A count of exactly 255 is not bus-off.
- R10: A one-cycle `busoff_clr` pulse clears the counter, `bus_off`, `err_passive`, `arb_lost` and any pending retry, and sets `tx_en` to 1.
- R11: After reset, `tx_en` is 1 and `arb_lost`, `err_req`, `retx_req`, `err_passive` and `bus_off` are 0.
- R12: Inputs are judged only on a strobe with `in_frame`=1. A mismatch without `bit_stb`, or with `in_frame`=0, raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busoff_clr | input | 1 | Recovery pulse: clears the counter and bus-off |
| bit_stb | input | 1 | One-cycle sample-point strobe |
| in_frame | input | 1 | The serializer is sending a frame of this node |
| in_arb_field | input | 1 | The current bit belongs to the arbitration field |
| in_ack_slot | input | 1 | The current bit is the acknowledge slot |
| last_bit | input | 1 | The current bit is the last bit of the frame |
| tx_bit | input | 1 | Bit being sent (0 dominant, 1 recessive) |
| rx_bit | input | 1 | Bus level sampled back |
| tx_en | output | 1 | Driver enable for the transceiver |
| arb_lost | output | 1 | Withdrawn after losing arbitration, until retry |
| err_req | output | 1 | One-cycle request for an error frame |
| retx_req | output | 1 | One-cycle request to resend the frame |
| err_passive | output | 1 | Error counter at or above 128 |
| bus_off | output | 1 | Node shut off the bus |

## Verification
Every result is registered once. It appears on the clock edge that samples the strobe and lasts one cycle (pulses) or until the next event (levels). The bench raises each strobe at a falling edge and drops it at the next falling edge, where it reads the outputs. That is the first point after the single register stage. The retry pulse is checked both at the tenth recessive strobe, where it must still be 0, and at the eleventh, where it must be 1. The counter thresholds are reached by exact numbers of errors and clean frames, so that 120, 127, 128, 255 and 263 each show on `err_passive` or `bus_off`.

// File: rtl/can_guard_pkg.sv
package can_guard_pkg;

  // Outcome of one read-back comparison
  typedef enum logic [1:0] {
    VERD_NONE     = 2'd0,
    VERD_ARB_LOST = 2'd1,
    VERD_BIT_ERR  = 2'd2,
    VERD_ACK_ERR  = 2'd3
  } verdict_t;

  localparam int unsigned DEF_ERR_STEP   = 8;
  localparam int unsigned DEF_OK_STEP    = 1;
  localparam int unsigned DEF_PASSIVE    = 128;
  localparam int unsigned DEF_BUSOFF_MAX = 255;
  localparam int unsigned DEF_IDLE_RUN   = 11;

endpackage

// File: rtl/cg_bit_judge.sv
module cg_bit_judge
  import can_guard_pkg::*;
(
  input  logic     tx_bit,
  input  logic     rx_bit,
  input  logic     in_arb,
  input  logic     in_ack,
  output verdict_t verdict
);

  always_comb begin
    verdict = VERD_NONE;
    if (in_ack) begin
      // recessive sent: a dominant read is the acknowledge, a recessive read is its absence
      if (tx_bit && rx_bit)       verdict = VERD_ACK_ERR;
      else if (!tx_bit && rx_bit) verdict = VERD_BIT_ERR;
    end else if (!tx_bit && rx_bit) begin
      verdict = VERD_BIT_ERR;
    end else if (tx_bit && !rx_bit) begin
      verdict = in_arb ? VERD_ARB_LOST : VERD_BIT_ERR;
    end
  end

endmodule

// File: rtl/cg_err_counter.sv
module cg_err_counter #(
  parameter int unsigned ERR_STEP   = 8,
  parameter int unsigned OK_STEP    = 1,
  parameter int unsigned PASSIVE    = 128,
  parameter int unsigned BUSOFF_MAX = 255
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic err_evt,
  input  logic ok_evt,
  output logic trip,
  output logic err_passive,
  output logic bus_off
);

  localparam int unsigned W = $clog2(BUSOFF_MAX + ERR_STEP + 1);
  localparam logic [W-1:0] STEP_UP = W'(ERR_STEP);
  localparam logic [W-1:0] STEP_DN = W'(OK_STEP);
  localparam logic [W-1:0] PAS_LVL = W'(PASSIVE);
  localparam logic [W-1:0] OFF_LVL = W'(BUSOFF_MAX);

  logic [W-1:0] tec_q, tec_n;
  logic         off_q, pas_q;

  always_comb begin
    tec_n = tec_q;
    if (clr)                tec_n = '0;
    else if (off_q)         tec_n = tec_q;
    else if (err_evt)       tec_n = tec_q + STEP_UP;
    else if (ok_evt)        tec_n = (tec_q >= STEP_DN) ? tec_q - STEP_DN : '0;
  end

  assign trip = !clr && !off_q && err_evt && ((tec_q + STEP_UP) > OFF_LVL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tec_q <= '0;
      off_q <= 1'b0;
      pas_q <= 1'b0;
    end else begin
      tec_q <= tec_n;
      off_q <= clr ? 1'b0 : (off_q || (tec_n > OFF_LVL));
      pas_q <= (tec_n >= PAS_LVL);
    end
  end

  assign err_passive = pas_q;
  assign bus_off     = off_q;

  // R3: every judged error adds the full step
  a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && !clr && !off_q) |=> (tec_q == $past(tec_q) + STEP_UP));

  // R7: a clean frame at zero leaves the counter at zero
  a_r7_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_evt && !err_evt && !clr && !off_q && tec_q == '0) |=> (tec_q == '0));

  // R9: bus-off holds until the recovery pulse
  a_r9_busoff_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q && !clr) |=> off_q);

  // R8: bus-off implies error-passive
  a_r8_passive_in_off: assert property (@(posedge clk) disable iff (!rst_n)
    off_q |-> pas_q);

endmodule

// File: rtl/cg_idle_watch.sv
module cg_idle_watch #(
  parameter int unsigned RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic bit_stb,
  input  logic rx_bit,
  output logic run_hit
);

  localparam int unsigned CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] cnt_q;

  assign run_hit = arm && bit_stb && rx_bit && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !arm)        cnt_q <= '0;
    else if (bit_stb) begin
      if (!rx_bit || run_hit)  cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
    end
  end

  // R6: the run counter never passes the idle length
  a_r6_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R6: a dominant read restarts the run
  a_r6_dom_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && bit_stb && !rx_bit) |=> (cnt_q == '0));

endmodule

// File: rtl/can_tx_guard.sv
module can_tx_guard
  import can_guard_pkg::*;
#(
  parameter int unsigned ERR_STEP   = DEF_ERR_STEP,
  parameter int unsigned OK_STEP    = DEF_OK_STEP,
  parameter int unsigned PASSIVE    = DEF_PASSIVE,
  parameter int unsigned BUSOFF_MAX = DEF_BUSOFF_MAX,
  parameter int unsigned IDLE_RUN   = DEF_IDLE_RUN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busoff_clr,
  input  logic bit_stb,
  input  logic in_frame,
  input  logic in_arb_field,
  input  logic in_ack_slot,
  input  logic last_bit,
  input  logic tx_bit,
  input  logic rx_bit,
  output logic tx_en,
  output logic arb_lost,
  output logic err_req,
  output logic retx_req,
  output logic err_passive,
  output logic bus_off
);

  verdict_t verdict;
  logic     pend_q, en_q, lost_q, err_q, retx_q;
  logic     judge_en, err_evt, arb_evt, ok_evt, trip, run_hit;

  cg_bit_judge u_judge (
    .tx_bit  (tx_bit),
    .rx_bit  (rx_bit),
    .in_arb  (in_arb_field),
    .in_ack  (in_ack_slot),
    .verdict (verdict)
  );

  // a bit counts only while a frame is live and no retry is pending
  assign judge_en = bit_stb && in_frame && !pend_q && !bus_off && !busoff_clr;
  assign err_evt  = judge_en && (verdict == VERD_BIT_ERR || verdict == VERD_ACK_ERR);
  assign arb_evt  = judge_en && (verdict == VERD_ARB_LOST);
  assign ok_evt   = judge_en && last_bit && (verdict == VERD_NONE);

  cg_err_counter #(
    .ERR_STEP   (ERR_STEP),
    .OK_STEP    (OK_STEP),
    .PASSIVE    (PASSIVE),
    .BUSOFF_MAX (BUSOFF_MAX)
  ) u_tec (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (busoff_clr),
    .err_evt     (err_evt),
    .ok_evt      (ok_evt),
    .trip        (trip),
    .err_passive (err_passive),
    .bus_off     (bus_off)
  );

  cg_idle_watch #(
    .RUN_LEN (IDLE_RUN)
  ) u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (pend_q && !bus_off),
    .bit_stb (bit_stb),
    .rx_bit  (rx_bit),
    .run_hit (run_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || busoff_clr) begin
      en_q   <= 1'b1;
      lost_q <= 1'b0;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
      retx_q <= 1'b0;
    end else begin
      err_q  <= err_evt;
      retx_q <= 1'b0;
      if (trip || bus_off) begin
        en_q   <= 1'b0;
        lost_q <= 1'b0;
        pend_q <= 1'b0;
      end else if (arb_evt) begin
        en_q   <= 1'b0;
        lost_q <= 1'b1;
        pend_q <= 1'b1;
      end else if (err_evt) begin
        pend_q <= 1'b1;
      end else if (run_hit) begin
        en_q   <= 1'b1;
        lost_q <= 1'b0;
        pend_q <= 1'b0;
        retx_q <= 1'b1;
      end
    end
  end

  assign tx_en    = en_q;
  assign arb_lost = lost_q;
  assign err_req  = err_q;
  assign retx_req = retx_q;

  // R1: a withdrawn node never drives
  a_r1_lost_silent: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> !tx_en);

  // R1: losing arbitration raises no error frame
  a_r1_loss_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> !err_req);

  // R3: the error request is a single pulse
  a_r3_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    err_req |=> !err_req);

  // R6: retry is a single pulse and ends the withdrawal
  a_r6_retx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    retx_req |-> (!arb_lost && tx_en) ##1 !retx_req);

  // R9: bus-off keeps the driver off and asks for no retry
  a_r9_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off |-> (!tx_en && !retx_req));

  // R10: the recovery pulse restores the driver
  a_r10_recover: assert property (@(posedge clk) disable iff (!rst_n)
    busoff_clr |=> (!bus_off && tx_en && !arb_lost));

endmodule

// File: tb/can_tx_guard_bench.sv
`timescale 1ns/1ps
module can_tx_guard_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0, busoff_clr = 1'b0, bit_stb = 1'b0;
  logic in_frame = 1'b0, in_arb_field = 1'b0, in_ack_slot = 1'b0, last_bit = 1'b0;
  logic tx_bit = 1'b1, rx_bit = 1'b1;
  logic tx_en, arb_lost, err_req, retx_req, err_passive, bus_off;
  int   n_vec = 0, n_bad = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  can_tx_guard u_can_tx_guard (
    .clk(clk), .rst_n(rst_n), .busoff_clr(busoff_clr), .bit_stb(bit_stb),
    .in_frame(in_frame), .in_arb_field(in_arb_field), .in_ack_slot(in_ack_slot),
    .last_bit(last_bit), .tx_bit(tx_bit), .rx_bit(rx_bit),
    .tx_en(tx_en), .arb_lost(arb_lost), .err_req(err_req), .retx_req(retx_req),
    .err_passive(err_passive), .bus_off(bus_off)
  );

  // bits: [9]frame [8]arb [7]ack [6]last [5]tx [4]rx | [3]tx_en [2]arb_lost [1]err_req [0]retx_req
  localparam int NV = 21;
  localparam logic [9:0] VEC [NV] = '{
    10'b110000_1000,  // R2 dominant match in arbitration
    10'b110011_1000,  // R2 recessive match in arbitration
    10'b100000_1000,  // R2 data match
    10'b101010_1000,  // R5 acknowledge received
    10'b100111_1000,  // R7 clean last bit at count 0
    10'b110011_1000,  // R2 new frame
    10'b110010_0100,  // R1 recessive sent, dominant read
    10'b100001_0100,  // R6 not judged while withdrawn (run 1)
    10'b100010_0100,  // R6 dominant read restarts run
    10'b000011_0100, 10'b000011_0100, 10'b000011_0100, 10'b000011_0100,
    10'b000011_0100, 10'b000011_0100, 10'b000011_0100, 10'b000011_0100,
    10'b000011_0100, 10'b000011_0100,  // R6 recessive runs 1..10
    10'b000011_1001,  // R6 eleventh recessive: retry
    10'b000011_1000   // R6 pulse ended
  };

  task automatic chk(input string tag, input logic got, input logic exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic step(input logic stb, input logic fr, input logic arb, input logic ack,
                      input logic last, input logic tb, input logic rb);
    @(negedge clk);
    bit_stb = stb; in_frame = fr; in_arb_field = arb; in_ack_slot = ack;
    last_bit = last; tx_bit = tb; rx_bit = rb;
    @(negedge clk);
    bit_stb = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; bit_stb = 1'b0; busoff_clr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // data-field bit error followed by a full idle run
  task automatic one_err(input string tag);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(tag, err_req, 1'b1);
    idle(11);
  endtask

  task automatic clean_frame;
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R11 reset state
    chk("R11 tx_en", tx_en, 1'b1);
    chk("R11 arb_lost", arb_lost, 1'b0);
    chk("R11 err_req", err_req, 1'b0);
    chk("R11 retx_req", retx_req, 1'b0);
    chk("R11 err_passive", err_passive, 1'b0);
    chk("R11 bus_off", bus_off, 1'b0);

    for (int v = 0; v < NV; v++) begin
      step(1'b1, VEC[v][9], VEC[v][8], VEC[v][7], VEC[v][6], VEC[v][5], VEC[v][4]);
      chk($sformatf("table row %0d tx_en", v), tx_en, VEC[v][3]);
      chk($sformatf("table row %0d arb_lost", v), arb_lost, VEC[v][2]);
      chk($sformatf("table row %0d err_req", v), err_req, VEC[v][1]);
      chk($sformatf("table row %0d retx_req", v), retx_req, VEC[v][0]);
    end

    // R12: mismatch without strobe, then strobe outside a frame
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R12 no strobe err_req", err_req, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R12 out of frame err_req", err_req, 1'b0);
    chk("R12 out of frame arb_lost", arb_lost, 1'b0);

    // R3: dominant sent, recessive read in data
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R3 err_req", err_req, 1'b1);
    chk("R3 arb_lost", arb_lost, 1'b0);
    chk("R3 tx_en", tx_en, 1'b1);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R3 pulse end", err_req, 1'b0);
    idle(10);
    chk("R6 ten recessive no retry", retx_req, 1'b0);
    idle(1);
    chk("R6 retry after error", retx_req, 1'b1);

    // R3: same mismatch inside arbitration is still an error
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R3 arb field err_req", err_req, 1'b1);
    chk("R3 arb field arb_lost", arb_lost, 1'b0);
    idle(11);

    // R4: recessive sent, dominant read in data
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R4 err_req", err_req, 1'b1);
    chk("R4 arb_lost", arb_lost, 1'b0);
    chk("R4 tx_en", tx_en, 1'b1);
    idle(11);
    chk("R4 retry", retx_req, 1'b1);

    // R5: no acknowledge
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R5 ack err_req", err_req, 1'b1);
    idle(11);
    chk("R5 retry", retx_req, 1'b1);

    // R7 and R8 thresholds from a fresh counter
    do_reset();
    clean_frame();                         // stays 0
    for (int i = 0; i < 15; i++) one_err("R8 ramp");
    chk("R8 at 120 err_passive", err_passive, 1'b0);
    one_err("R8 step to 128");
    chk("R7 floor then R8 at 128 err_passive", err_passive, 1'b1);
    clean_frame();
    chk("R7 down to 127 err_passive", err_passive, 1'b0);
    one_err("R8 step to 135");
    chk("R8 at 135 err_passive", err_passive, 1'b1);

    // R9: bus-off boundary
    for (int i = 0; i < 15; i++) one_err("R9 ramp");
    chk("R9 at 255 bus_off", bus_off, 1'b0);
    chk("R9 at 255 tx_en", tx_en, 1'b1);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R9 trip err_req", err_req, 1'b1);
    chk("R9 trip bus_off", bus_off, 1'b1);
    chk("R9 trip tx_en", tx_en, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R9 no err in bus-off", err_req, 1'b0);
    idle(12);
    chk("R9 no retry in bus-off", retx_req, 1'b0);
    chk("R9 still off tx_en", tx_en, 1'b0);

    // R10: recovery
    @(negedge clk); busoff_clr = 1'b1;
    @(negedge clk); busoff_clr = 1'b0;
    chk("R10 bus_off", bus_off, 1'b0);
    chk("R10 tx_en", tx_en, 1'b1);
    chk("R10 err_passive", err_passive, 1'b0);
    one_err("R10 fresh error");
    chk("R10 counter cleared err_passive", err_passive, 1'b0);

    // R10: recovery also drops a pending withdrawal
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R1 loss arb_lost", arb_lost, 1'b1);
    @(negedge clk); busoff_clr = 1'b1;
    @(negedge clk); busoff_clr = 1'b0;
    chk("R10 clears arb_lost", arb_lost, 1'b0);
    chk("R10 restores tx_en", tx_en, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule